// File: doc/BRIEF.md
# Power-Line Carrier Frame Receiver

This block rebuilds home-automation command frames sent over the mains wiring. It watches the demodulated receive line from a carrier modem. Each falling edge on that line marks a mains half cycle that carried a burst. A zero bit sends no burst, so the block infers each bit from the time since the previous accepted pulse, read against the value of the bit before it. A free-running microsecond timestamp measures these gaps. The sampled zero-crossing level tracks which mains phase a pulse falls on.

A frame opens with three burst half cycles and one silent half cycle. Nine data bits follow: four house bits, then five key bits, sent most significant first. Each bit takes two half cycles. When a frame ends, by completing, by an error or by the silence timeout, the block issues a three-byte result with a one-cycle strobe. The bytes are a flag byte, a house index and a key index. A busy input from the local transmitter lets the block mark frames it heard while the chip itself was sending. The result has no back-pressure. The consumer must take every strobe on the cycle it occurs, and the result bytes stay unchanged until the next strobe.

Top module: `plc_frame_rx`

## Requirements
- R1: While idle, any falling edge on `rx_line` opens a frame and counts as the first start "1". Flag bit 0 (local) of that frame's result is 1 when `tx_busy` is high on the edge's cycle.
- R2: During a frame, an edge less than 1500 us after the last accepted pulse is ignored. It changes neither the decoded bits nor the silence timer.
- R3: The second and third start pulses must each come 1 half cycle (8333 us ±1388 us) after the previous pulse, with `zc_level` different from its level at that previous pulse. Otherwise the frame is dropped with no result, and the block returns to idle.
- R4: After the third start pulse, the block assumes the start code's trailing 0. It treats the first data pulse as following a 1 bit.
- R5: After a 1 bit, a gap of 2 half cycles decodes 1 and a gap of 3 decodes 0. After a 0 bit, a gap of 1 half cycle decodes 1 and a gap of 2 decodes 0. Every window is ±1388 us around its centre.
- R6: The 9 decoded bits shift into a register, first bit at bit 8. The frame completes at 22 half cycles. The house index is table[bits 8:5], with table = 12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9. The key index for code c is that same table at c>>1 when c is even, and 16+(c>>1) when c is odd. Flag bit 1 is 0.
- R7: A data gap that fits no window ends the frame at once. The result has flag bit 1 (error) set, and house and key are 0.
- R8: Each accepted pulse restarts a 50 ms silence timer. If the timer runs out mid-frame after exactly one pulse, the frame is dropped silently. If it runs out after two or more pulses, the block emits an error result with house 0 and key 0.
- R9: Gaps are computed modulo 2^16 of `now_us`, so frames that span the timestamp wrapping decode correctly.
- R10: `out_valid` is high for exactly one cycle per result. Flag bits 7:2 are 0. The result bytes hold their value until the next result.
- R11: Edges are ignored while `rx_disable` is high. Such an edge starts no frame.
- R12: After reset, `out_valid` and all result bytes are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Demodulated receive line; a falling edge marks a carrier half cycle |
| zc_level | input | 1 | Sampled mains zero-crossing level (phase) |
| now_us | input | 16 | Free-running microsecond timestamp |
| tx_busy | input | 1 | High while the local transmitter is sending |
| rx_disable | input | 1 | Ignore receive edges while high |
| out_valid | output | 1 | One-cycle result strobe, no back-pressure |
| out_flags | output | 8 | Bit 0 local, bit 1 error, others 0 |
| out_house | output | 8 | Decoded house index 0..15 |
| out_key | output | 8 | Decoded key index 0..31 |

## Verification
The hardest cases to reach are the silence timeout and timestamp wrap. A real frame lasts about 183 ms and a timeout needs 50 ms of silence, which would take millions of clock cycles if time advanced at its real rate. The bench owns `now_us` and moves it by whole pulse gaps, or by 1000 us per clock during silence. This lets each frame wrap the 16-bit timestamp and lets the timeout fire within a few dozen cycles. The timeout is run after one pulse and after two pulses, to separate the silent drop from the error result.

// File: rtl/plc_rx_pkg.sv
package plc_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA
  } rx_state_e;

  localparam int FLAG_LOCAL = 0;
  localparam int FLAG_ERR   = 1;

  // maps the 4-bit received house pattern to its index
  function automatic logic [3:0] house_of(input logic [3:0] c);
    logic [3:0] r;
    case (c)
      4'd0:  r = 4'd12;
      4'd1:  r = 4'd4;
      4'd2:  r = 4'd2;
      4'd3:  r = 4'd10;
      4'd4:  r = 4'd14;
      4'd5:  r = 4'd6;
      4'd6:  r = 4'd0;
      4'd7:  r = 4'd8;
      4'd8:  r = 4'd13;
      4'd9:  r = 4'd5;
      4'd10: r = 4'd3;
      4'd11: r = 4'd11;
      4'd12: r = 4'd15;
      4'd13: r = 4'd7;
      4'd14: r = 4'd1;
      default: r = 4'd9;
    endcase
    return r;
  endfunction

  // key patterns: even codes reuse the house map, odd codes are the function range
  function automatic logic [4:0] key_of(input logic [4:0] c);
    return c[0] ? {1'b1, c[4:1]} : {1'b0, house_of(c[4:1])};
  endfunction

endpackage

// File: rtl/plc_rx_edge.sv
module plc_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic gate_off,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= rx_line;
  end

  assign fall_o = prev_q & ~rx_line & ~gate_off;
endmodule

// File: rtl/plc_span_class.sv
module plc_span_class #(
  parameter int TS_W       = 16,
  parameter int HALF_US    = 8333,
  parameter int TOL_US     = 1388,
  parameter int MIN_GAP_US = 1500
) (
  input  logic [TS_W-1:0] now_us,
  input  logic [TS_W-1:0] ref_us,
  output logic            gap_ok,
  output logic [3:1]      in_win
);
  localparam int DW = TS_W + 3;
  localparam logic signed [DW-1:0] TOLV = DW'(TOL_US);

  logic [TS_W-1:0] delta;
  logic signed [DW-1:0] dv;

  assign delta  = now_us - ref_us;   // modulo the timestamp width
  assign dv     = signed'({3'b000, delta});
  assign gap_ok = delta >= TS_W'(MIN_GAP_US);

  for (genvar k = 1; k <= 3; k++) begin : g_win
    localparam logic signed [DW-1:0] CENTER = DW'(k * HALF_US);
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] mag;
    assign diff      = dv - CENTER;
    assign mag       = (diff < 0) ? -diff : diff;
    assign in_win[k] = mag < TOLV;
  end
endmodule

// File: rtl/plc_rx_silence.sv
module plc_rx_silence #(
  parameter int TS_W     = 16,
  parameter int LIMIT_US = 50000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now_us,
  input  logic            restart,
  output logic            expired
);
  localparam int SW = TS_W + $clog2(LIMIT_US + 1);
  localparam logic [SW-1:0] LIM = SW'(LIMIT_US);

  logic [SW-1:0]   acc_q;
  logic [SW-1:0]   sum;
  logic [TS_W-1:0] prev_q;
  logic [TS_W-1:0] step;

  assign step    = now_us - prev_q;
  assign sum     = acc_q + SW'(step);
  assign expired = acc_q >= LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= now_us;
      if (restart)         acc_q <= '0;
      else if (sum >= LIM) acc_q <= LIM;
      else                 acc_q <= sum;
    end
  end
endmodule

// File: rtl/plc_frame_rx.sv
module plc_frame_rx
  import plc_rx_pkg::*;
#(
  parameter int TS_W          = 16,
  parameter int HALF_US       = 8333,
  parameter int MIN_GAP_US    = 1500,
  parameter int SILENCE_US    = 50000,
  parameter int FRAME_HALVES  = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_line,
  input  logic            zc_level,
  input  logic [TS_W-1:0] now_us,
  input  logic            tx_busy,
  input  logic            rx_disable,
  output logic            out_valid,
  output logic [7:0]      out_flags,
  output logic [7:0]      out_house,
  output logic [7:0]      out_key
);
  localparam int TOL_US  = HALF_US / 6;
  localparam int HOUSE_W = 4;
  localparam int KEY_W   = 5;
  localparam int CODE_W  = HOUSE_W + KEY_W;
  localparam int HC_W    = $clog2(FRAME_HALVES + 1);

  rx_state_e       state_q;
  logic [HC_W-1:0] hcnt_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_n;
  logic            last_bit_q;
  logic            rphase_q;
  logic            local_q;
  logic [TS_W-1:0] last_ts_q;
  logic            busy_q;

  logic            fall;
  logic            gap_ok;
  logic [3:1]      in_win;
  logic            expired;
  logic            accept;
  logic            timeout;
  logic            take;
  logic            start_ok;
  logic            bit_val;
  logic            bit_bad;

  plc_rx_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_line  (rx_line),
    .gate_off (rx_disable),
    .fall_o   (fall)
  );

  plc_span_class #(
    .TS_W       (TS_W),
    .HALF_US    (HALF_US),
    .TOL_US     (TOL_US),
    .MIN_GAP_US (MIN_GAP_US)
  ) u_span (
    .now_us (now_us),
    .ref_us (last_ts_q),
    .gap_ok (gap_ok),
    .in_win (in_win)
  );

  plc_rx_silence #(
    .TS_W     (TS_W),
    .LIMIT_US (SILENCE_US)
  ) u_sil (
    .clk     (clk),
    .rst_n   (rst_n),
    .now_us  (now_us),
    .restart (take),
    .expired (expired)
  );

  assign busy_q   = state_q != ST_IDLE;
  assign timeout  = busy_q && expired;
  assign accept   = fall && (!busy_q || gap_ok);
  assign take     = accept && !timeout;
  assign start_ok = in_win[1] && (zc_level != rphase_q);
  assign code_n   = {code_q[CODE_W-2:0], bit_val};

  // bit inference from the gap, relative to the previous bit
  always_comb begin
    bit_val = 1'b0;
    bit_bad = 1'b0;
    if (last_bit_q) begin
      if (in_win[2])      bit_val = 1'b1;
      else if (in_win[3]) bit_val = 1'b0;
      else                bit_bad = 1'b1;
    end else begin
      if (in_win[1])      bit_val = 1'b1;
      else if (in_win[2]) bit_val = 1'b0;
      else                bit_bad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hcnt_q     <= '0;
      code_q     <= '0;
      last_bit_q <= 1'b0;
      rphase_q   <= 1'b0;
      local_q    <= 1'b0;
      last_ts_q  <= '0;
      out_valid  <= 1'b0;
      out_flags  <= '0;
      out_house  <= '0;
      out_key    <= '0;
    end else begin
      out_valid <= 1'b0;
      if (timeout) begin
        state_q <= ST_IDLE;
        if (hcnt_q > HC_W'(1)) begin
          out_valid <= 1'b1;
          out_flags <= {6'b0, 1'b1, local_q};
          out_house <= '0;
          out_key   <= '0;
        end
      end else if (take) begin
        last_ts_q <= now_us;
        unique case (state_q)
          ST_IDLE: begin
            state_q  <= ST_START;
            hcnt_q   <= HC_W'(1);
            local_q  <= tx_busy;
            rphase_q <= zc_level;
          end
          ST_START: begin
            if (start_ok) begin
              rphase_q <= zc_level;
              if (hcnt_q == HC_W'(2)) begin
                // third start pulse: assume the silent trailing zero
                hcnt_q     <= HC_W'(4);
                last_bit_q <= 1'b1;
                code_q     <= '0;
                state_q    <= ST_DATA;
              end else begin
                hcnt_q <= hcnt_q + HC_W'(1);
              end
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: begin
            if (bit_bad) begin
              state_q   <= ST_IDLE;
              out_valid <= 1'b1;
              out_flags <= {6'b0, 1'b1, local_q};
              out_house <= '0;
              out_key   <= '0;
            end else begin
              code_q     <= code_n;
              last_bit_q <= bit_val;
              hcnt_q     <= hcnt_q + HC_W'(2);
              if (hcnt_q + HC_W'(2) == HC_W'(FRAME_HALVES)) begin
                state_q   <= ST_IDLE;
                out_valid <= 1'b1;
                out_flags <= {6'b0, 1'b0, local_q};
                out_house <= {4'b0, house_of(code_n[CODE_W-1:KEY_W])};
                out_key   <= {3'b0, key_of(code_n[KEY_W-1:0])};
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/plc_frame_rx_chk.sv
module plc_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_disable,
  input logic       busy,
  input logic       out_valid,
  input logic [7:0] out_flags,
  input logic [7:0] out_house,
  input logic [7:0] out_key
);
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_result_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[7:2] == 6'd0 && out_house < 8'd16 && out_key < 8'd32));

  p_error_zeroed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> (out_house == 8'd0 && out_key == 8'd0));

  p_disable_no_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_disable) |=> !busy);

  p_result_ends_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(busy) && !busy));

  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_house) && $stable(out_key) && $stable(out_flags)));
endmodule

bind plc_frame_rx plc_frame_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_disable (rx_disable),
  .busy       (busy_q),
  .out_valid  (out_valid),
  .out_flags  (out_flags),
  .out_house  (out_house),
  .out_key    (out_key)
);

// File: tb/plc_frame_rx_bench.sv
`timescale 1ns/1ps
module plc_frame_rx_bench;
  localparam int HALF = 8333;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic        zc_level = 1'b0;
  logic [15:0] now_us = '0;
  logic        tx_busy = 1'b0;
  logic        rx_disable = 1'b0;
  logic        out_valid;
  logic [7:0]  out_flags, out_house, out_key;

  int n_tests = 0;
  int n_fail = 0;
  int n_res = 0;
  int dbl = 0;
  bit done = 0;
  int t = 0;
  logic [7:0] r_flags, r_house, r_key;
  bit prev_v = 0;

  int htab [16] = '{12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9};
  int ktab [32] = '{12,16,4,17,2,18,10,19,14,20,6,21,0,22,8,23,
                    13,24,5,25,3,26,11,27,15,28,7,29,1,30,9,31};

  always #2 clk = ~clk;

  plc_frame_rx u_plc_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .zc_level(zc_level),
    .now_us(now_us), .tx_busy(tx_busy), .rx_disable(rx_disable),
    .out_valid(out_valid), .out_flags(out_flags), .out_house(out_house),
    .out_key(out_key)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      n_res++;
      r_flags = out_flags; r_house = out_house; r_key = out_key;
      if (prev_v) dbl++;
    end
    prev_v = out_valid;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_at(int tus, bit zc);
    @(negedge clk); now_us = 16'(tus); zc_level = zc; rx_line = 1'b0;
    @(negedge clk); rx_line = 1'b1;
  endtask

  task automatic silence();
    repeat (60) begin @(negedge clk); t += 1000; now_us = 16'(t); end
    @(negedge clk);
  endtask

  task automatic send_frame(logic [8:0] code, int jit, bit glitch);
    int tc = t;
    int hp = 2;
    pulse_at(tc, 1'b0);
    tc += HALF + jit;  pulse_at(tc, 1'b1);
    tc += HALF - jit;  pulse_at(tc, 1'b0);
    for (int j = 0; j < 9; j++) begin
      int h = 4 + 2 * j + (code[8-j] ? 0 : 1);
      tc += (h - hp) * HALF + ((j % 2) ? jit : -jit);
      pulse_at(tc, 1'(h % 2));
      if (glitch && j == 2) pulse_at(tc + 600, 1'(h % 2));
      hp = h;
    end
    t = tc + 100000;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic frame_case(string req, logic [8:0] code, int jit, bit glitch, bit loc);
    int n0 = n_res;
    tx_busy = loc;
    send_frame(code, jit, glitch);
    tx_busy = 1'b0;
    chk(n_res == n0 + 1, req, "result count", n_res - n0, 1);
    chk(r_flags == 8'(loc), req, "flags", r_flags, loc);
    chk(r_house == 8'(htab[code[8:5]]), req, "house", r_house, htab[code[8:5]]);
    chk(r_key == 8'(ktab[code[4:0]]), req, "key", r_key, ktab[code[4:0]]);
  endtask

  task automatic test_reset();
    chk(out_valid == 1'b0, "R12", "valid", out_valid, 0);
    chk(out_flags == 0 && out_house == 0 && out_key == 0, "R12", "result bytes",
        out_flags + out_house + out_key, 0);
  endtask

  task automatic test_bad_start_spacing();
    int n0 = n_res;
    pulse_at(t, 1'b0); pulse_at(t + 2 * HALF, 1'b1);
    t += 2 * HALF; silence();
    chk(n_res == n0, "R3", "results after bad start gap", n_res - n0, 0);
  endtask

  task automatic test_bad_start_phase();
    int n0 = n_res;
    pulse_at(t, 1'b0); pulse_at(t + HALF, 1'b0);
    t += HALF; silence();
    chk(n_res == n0, "R3", "results after same-phase start", n_res - n0, 0);
  endtask

  task automatic test_disable();
    int n0 = n_res;
    rx_disable = 1'b1;
    pulse_at(t, 1'b0); pulse_at(t + HALF, 1'b1); pulse_at(t + 2 * HALF, 1'b0);
    rx_disable = 1'b0;
    t += 2 * HALF; silence();
    chk(n_res == n0, "R11", "results while disabled", n_res - n0, 0);
  endtask

  task automatic test_lone_timeout();
    int n0 = n_res;
    pulse_at(t, 1'b0); silence();
    chk(n_res == n0, "R8", "lone pulse timeout results", n_res - n0, 0);
  endtask

  task automatic test_multi_timeout();
    int n0 = n_res;
    pulse_at(t, 1'b0); pulse_at(t + HALF, 1'b1);
    t += HALF; silence();
    chk(n_res == n0 + 1, "R8", "timeout result count", n_res - n0, 1);
    chk(r_flags == 8'd2 && r_house == 0 && r_key == 0, "R8", "timeout flags",
        r_flags, 2);
  endtask

  task automatic test_bad_data();
    int n0 = n_res;
    tx_busy = 1'b1;
    pulse_at(t, 1'b0);
    tx_busy = 1'b0;
    pulse_at(t + HALF, 1'b1); pulse_at(t + 2 * HALF, 1'b0);
    pulse_at(t + 3 * HALF, 1'b1);   // 1 half after a 1: no window
    @(negedge clk); @(negedge clk);
    t += 200000;
    chk(n_res == n0 + 1, "R7", "bad data result count", n_res - n0, 1);
    chk(r_flags == 8'd3, "R7", "bad data flags", r_flags, 3);
    chk(r_house == 0 && r_key == 0, "R7", "bad data house+key", r_house + r_key, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    t = 1000;
    frame_case("R6", 9'h1FF, 0, 1'b0, 1'b0);
    frame_case("R5", 9'h000, 0, 1'b0, 1'b0);
    frame_case("R5", 9'b1010_01101, 1000, 1'b0, 1'b0);
    frame_case("R4", 9'b0110_10010, -1000, 1'b0, 1'b0);
    frame_case("R1", 9'b0011_00111, 0, 1'b0, 1'b1);
    t = 65536 - 9000;
    frame_case("R9", 9'b1100_11000, 700, 1'b0, 1'b0);
    frame_case("R2", 9'b0101_01010, 0, 1'b1, 1'b0);
    test_bad_start_spacing();
    test_bad_start_phase();
    test_disable();
    test_lone_timeout();
    test_multi_timeout();
    test_bad_data();
    frame_case("R3", 9'b1001_10001, 0, 1'b0, 1'b0);
    chk(dbl == 0, "R10", "double-cycle strobes", dbl, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule